// File: doc/BRIEF.md
# Serial Fractional Signed Divider

This block divides one signed fixed-point fraction by another and keeps running without any command word. Each word slot is W bit times long, and a one-cycle frame strobe marks its first bit. During a slot the dividend and the divisor arrive one bit per bit time, least significant bit first. In the slot that follows, the block builds the quotient with signed non-restoring iteration, one quotient digit per bit time. A correction at the end turns the digit string from the set {-1,+1} into a two's complement word rounded toward negative infinity. In the slot after that, the quotient leaves the block serially, least significant bit first. Loading, computing and sending overlap, so a new operand pair can enter in every slot.

Operands and quotient are W-bit two's complement fractions: a word x stands for x / 2^(W-1), which lies in [-1, 1). A division whose result cannot be represented is flagged. This happens when the divisor magnitude is not larger than the dividend magnitude, and zero divisors are included. A flagged division does not give a quotient; it gives a saturated value.

Top module: `frac_serial_divider`

## Requirements
- R1: The frame strobe is high in the bit time that carries bit 0 (LSB) of a new word. Dividend and divisor bits j = 0..W-1 are sampled on the W consecutive rising edges that start at that edge.
- R2: The result for operands framed at edge e0 is loaded at edge e0+2W. Quotient bit j is on the serial output during the cycle after edge e0+2W+j, LSB first.
- R3: When no fault is raised, the quotient word equals floor(A * 2^(W-1) / B), taken as a W-bit two's complement word, where A and B are the dividend and divisor words as signed integers. The rounding is toward negative infinity.
- R4: The fault flag is raised for a division exactly when |B| <= |A|. This covers B = 0 for every dividend.
- R5: A faulted division gives the largest positive word (0 followed by ones) when the sign bits of A and B are equal. Otherwise it gives the most negative word (1 followed by zeros). B = 0 counts as non-negative.
- R6: The fault flag for a division is valid for the whole slot in which its quotient is shifted out. It changes only on the edge where a result is loaded.
- R7: Operand pairs in back-to-back slots each produce their own correct result, with no idle slot and no command.
- R8: After reset the quotient output and the fault flag are 0 until the first result is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | High with bit 0 of each word slot |
| dvd_i | input | 1 | Serial dividend, LSB first |
| dvs_i | input | 1 | Serial divisor, LSB first |
| quo_o | output | 1 | Serial quotient, LSB first |
| fault_o | output | 1 | Divide fault flag for the word being sent |

## Verification
The bench builds the divider with W = 6, which leaves 5 iteration steps and a 6-bit word. At that width every one of the 4096 dividend/divisor pairs can be streamed back to back in about 25 thousand bit times. The full sweep reaches every zero-remainder case and every correction direction, including a remainder equal to the divisor. It also covers both saturation signs, the zero divisor with each dividend sign, and the most negative operand as dividend and as divisor. The expected quotient comes from integer floor division done in the bench.

// File: rtl/fsd_pkg.sv
`timescale 1ns/1ps
package fsd_pkg;

    // Final adjustment applied to the raw quotient built from +/-1 digits
    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_DEC  = 2'd1,
        ADJ_INC  = 2'd2
    } adj_e;

endpackage

// File: rtl/fsd_deser.sv
`timescale 1ns/1ps
// Two serial-to-parallel shift registers; the full words are valid at the frame edge
module fsd_deser #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dvd_bit_i,
    input  logic         dvs_bit_i,
    output logic [W-1:0] dvd_word_o,
    output logic [W-1:0] dvs_word_o
);

    typedef struct packed {
        logic [W-1:0] dvd;
        logic [W-1:0] dvs;
    } deser_t;

    deser_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // LSB arrives first, so fresh bits enter at the top
        st_d.dvd = {dvd_bit_i, st_q.dvd[W-1:1]};
        st_d.dvs = {dvs_bit_i, st_q.dvs[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dvd_word_o = st_q.dvd;
    assign dvs_word_o = st_q.dvs;

endmodule

// File: rtl/fsd_core.sv
`timescale 1ns/1ps
// Signed non-restoring iteration, one digit per bit time, plus digit-set correction
module fsd_core
    import fsd_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] quo_o,
    output logic         fault_o
);

    localparam int N  = W - 1;           // quotient digits after the sign
    localparam int RW = W + 2;           // remainder width, room for 2r +/- b
    localparam int CW = $clog2(W) + 1;
    localparam logic [W-1:0] MAX_POS = {1'b0, {N{1'b1}}};
    localparam logic [W-1:0] MAX_NEG = {1'b1, {N{1'b0}}};

    typedef struct packed {
        logic [RW-1:0] rem;
        logic [RW-1:0] dvs;
        logic [N-1:0]  pos;      // 1 where the digit is +1, 0 where it is -1
        logic [CW-1:0] cnt;
        logic          fault;
        logic          sat_neg;
    } work_t;

    work_t st_d, st_q;

    logic [W:0]    ext_a, ext_b, mag_a, mag_b;
    logic [RW-1:0] rem_dbl;
    logic          same_sign;
    logic [W-1:0]  q_raw;
    logic [W-1:0]  q_fix;
    adj_e          adj;

    always_comb begin
        ext_a     = {dvd_i[W-1], dvd_i};
        ext_b     = {dvs_i[W-1], dvs_i};
        mag_a     = ext_a[W] ? (~ext_a + 1'b1) : ext_a;
        mag_b     = ext_b[W] ? (~ext_b + 1'b1) : ext_b;
        rem_dbl   = {st_q.rem[RW-2:0], 1'b0};
        same_sign = (st_q.rem[RW-1] == st_q.dvs[RW-1]);

        st_d = st_q;
        if (load_i) begin
            st_d.rem     = {{2{dvd_i[W-1]}}, dvd_i};
            st_d.dvs     = {{2{dvs_i[W-1]}}, dvs_i};
            st_d.pos     = '0;
            st_d.cnt     = '0;
            st_d.fault   = (mag_b <= mag_a);
            st_d.sat_neg = dvd_i[W-1] ^ dvs_i[W-1];
        end else if (st_q.cnt < CW'(N)) begin
            st_d.rem = same_sign ? (rem_dbl - st_q.dvs) : (rem_dbl + st_q.dvs);
            st_d.pos = {st_q.pos[N-2:0], same_sign};
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Digits {-1,+1} to two's complement: 2P - 2^N + 1
    always_comb begin
        q_raw = {~st_q.pos[N-1], st_q.pos[N-2:0], 1'b1};
        if (st_q.rem == st_q.dvs && st_q.rem != '0)
            adj = ADJ_INC;
        else if (st_q.rem != '0 && st_q.rem[RW-1] != st_q.dvs[RW-1])
            adj = ADJ_DEC;
        else
            adj = ADJ_NONE;
        case (adj)
            ADJ_INC: q_fix = q_raw + 1'b1;
            ADJ_DEC: q_fix = q_raw - 1'b1;
            default: q_fix = q_raw;
        endcase
        if (st_q.fault) quo_o = st_q.sat_neg ? MAX_NEG : MAX_POS;
        else            quo_o = q_fix;
    end

    assign fault_o = st_q.fault;

endmodule

// File: rtl/fsd_ser.sv
`timescale 1ns/1ps
// Parallel-to-serial quotient register with its fault flag
module fsd_ser #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] quo_i,
    input  logic         fault_i,
    output logic         quo_bit_o,
    output logic         fault_o,
    output logic [W-1:0] word_o
);

    typedef struct packed {
        logic [W-1:0] sh;
        logic         fault;
    } ser_t;

    ser_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sh    = quo_i;
            st_d.fault = fault_i;
        end else begin
            st_d.sh = {1'b0, st_q.sh[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign quo_bit_o = st_q.sh[0];
    assign fault_o   = st_q.fault;
    assign word_o    = st_q.sh;

endmodule

// File: rtl/frac_serial_divider.sv
`timescale 1ns/1ps
module frac_serial_divider #(
    parameter int W = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_i,
    input  logic dvd_i,
    input  logic dvs_i,
    output logic quo_o,
    output logic fault_o
);

    logic [W-1:0] dvd_word, dvs_word;
    logic [W-1:0] core_quo;
    logic         core_fault;
    logic [W-1:0] ser_word;

    fsd_deser #(.W(W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .dvd_bit_i  (dvd_i),
        .dvs_bit_i  (dvs_i),
        .dvd_word_o (dvd_word),
        .dvs_word_o (dvs_word)
    );

    fsd_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (frame_i),
        .dvd_i   (dvd_word),
        .dvs_i   (dvs_word),
        .quo_o   (core_quo),
        .fault_o (core_fault)
    );

    fsd_ser #(.W(W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (frame_i),
        .quo_i     (core_quo),
        .fault_i   (core_fault),
        .quo_bit_o (quo_o),
        .fault_o   (fault_o),
        .word_o    (ser_word)
    );

endmodule

// File: rtl/fsd_checker.sv
`timescale 1ns/1ps
module fsd_checker #(
    parameter int W = 20
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frame_i,
    input logic         fault_o,
    input logic [W-1:0] core_quo,
    input logic         core_fault,
    input logic [W-1:0] ser_word
);

    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

    // R2: result handed from the iteration stage to the output stage on the frame edge
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> (ser_word == $past(core_quo)) && (fault_o == $past(core_fault)));

    // R2: between frames the output word moves one bit toward the pin per edge
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> ser_word == ($past(ser_word) >> 1));

    // R6: flag holds through the slot
    p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> $stable(fault_o));

    // R5: a faulted result is always one of the two saturation words
    p_fault_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_fault |-> (core_quo == MAX_POS || core_quo == MAX_NEG));

endmodule

bind frac_serial_divider fsd_checker #(.W(W)) u_fsd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_i    (frame_i),
    .fault_o    (fault_o),
    .core_quo   (core_quo),
    .core_fault (core_fault),
    .ser_word   (ser_word)
);

// File: tb/frac_serial_divider_bench.sv
`timescale 1ns/1ps
module frac_serial_divider_bench;

    localparam int W  = 6;
    localparam int NW = 1 << (2 * W);

    logic clk = 1'b0;
    logic rst_n, frame_i, dvd_i, dvs_i;
    logic quo_o, fault_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    frac_serial_divider #(.W(W)) u_frac_serial_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (frame_i),
        .dvd_i   (dvd_i),
        .dvs_i   (dvs_i),
        .quo_o   (quo_o),
        .fault_o (fault_o)
    );

    function automatic int to_int(logic [W-1:0] v);
        return int'($signed(v));
    endfunction

    // {fault, quotient} from R3, R4, R5
    function automatic logic [W:0] model(int a, int b);
        int ma, mb, n, q;
        bit flt;
        ma  = (a < 0) ? -a : a;
        mb  = (b < 0) ? -b : b;
        flt = (mb <= ma);
        if (flt) begin
            q = ((a < 0) == (b < 0)) ? ((1 << (W - 1)) - 1) : -(1 << (W - 1));
        end else begin
            n = a * (1 << (W - 1));
            q = n / b;
            if ((n % b) != 0 && ((n < 0) != (b < 0))) q = q - 1;
        end
        return {flt, q[W-1:0]};
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete (actual hung, expected finished)");
            summary();
            $finish;
        end
    end

    initial begin
        logic [W-1:0] got_q;
        logic         first_fault;
        bit           fault_moved;
        rst_n   = 1'b0;
        frame_i = 1'b0;
        dvd_i   = 1'b0;
        dvs_i   = 1'b0;
        got_q       = '0;
        first_fault = 1'b0;
        fault_moved = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: idle outputs after reset
        n_checks++;
        if (quo_o !== 1'b0 || fault_o !== 1'b0) begin
            n_fails++;
            $display("FAIL R8: after reset quo=%b fault=%b, expected 0 0", quo_o, fault_o);
        end

        for (int c = 0; c <= (NW + 2) * W; c++) begin
            @(negedge clk);
            // Observe: value reflects edge c-1 (R2 timing)
            if (c - 1 >= 2 * W) begin
                int idx, w, j;
                idx = c - 1 - 2 * W;
                w   = idx / W;
                j   = idx % W;
                if (w < NW) begin
                    got_q[j] = quo_o;
                    if (j == 0) begin
                        first_fault = fault_o;
                        fault_moved = 1'b0;
                    end else if (fault_o !== first_fault) begin
                        fault_moved = 1'b1;
                    end
                    if (j == W - 1) begin
                        logic [W-1:0] wa, wb;
                        logic [W:0]   exp_v;
                        logic [W:0]   act_v;
                        wa    = w[2*W-1:W];
                        wb    = w[W-1:0];
                        exp_v = model(to_int(wa), to_int(wb));
                        act_v = {first_fault, got_q};
                        n_checks++;
                        if (act_v !== exp_v || fault_moved) begin
                            n_fails++;
                            if (exp_v[W])
                                $display("FAIL R4 R5 R6: a=%0d b=%0d actual fault=%b q=%b moved=%b, expected fault=%b q=%b",
                                         to_int(wa), to_int(wb), act_v[W], act_v[W-1:0], fault_moved,
                                         exp_v[W], exp_v[W-1:0]);
                            else
                                $display("FAIL R3 R1 R2 R7: a=%0d b=%0d actual fault=%b q=%b, expected fault=%b q=%b",
                                         to_int(wa), to_int(wb), act_v[W], act_v[W-1:0],
                                         exp_v[W], exp_v[W-1:0]);
                        end
                    end
                end
            end
            // Drive: bit for edge c (R1 framing, R7 back-to-back words)
            begin
                int w, j;
                logic [W-1:0] wa, wb;
                w  = c / W;
                j  = c % W;
                wa = (w < NW) ? w[2*W-1:W] : '0;
                wb = (w < NW) ? w[W-1:0]   : '0;
                frame_i = (j == 0);
                dvd_i   = wa[j];
                dvs_i   = wb[j];
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule